// File: doc/BRIEF.md
# Linked Descriptor Capture Engine

This engine walks a list of 32-bit descriptor words held in a local word-addressed SRAM. The walk begins at a list index given with the start pulse. As it goes, it issues single-word reads and writes on a request/response bus port. Every word it reads from the bus is stored back into the same SRAM at consecutive indices, beginning at a data index also given with the start pulse. The walk ends at an end-of-list marker, or at the first bus error. It then raises `done` for one cycle, with `err` showing how the walk ended.

The top two bits of each descriptor give its kind:

- **Base word.** Sets the bus base address, the direction (read or write) and the bus select flag.
- **Link word.** Packs up to two offset/count pairs. Each pair names a run of consecutive bus words.
- **Loop word.** Sends the walk back a counted number of list words for a given number of extra passes.
- **Read-modify-write word.** Is followed by a mask word and a value word. It rewrites the most recently captured location.

Top module: `lcap_engine`

## Requirements
- R1: After reset, and while no walk is running, `busy`, `done`, `err`, `bus_req` and `mem_en` are all 0. A one-cycle `start` pulse in idle loads the list index from `list_base` and the data pointer `wr_ptr` from `data_base`.
- R2: Bits [31:30] of a descriptor select its kind: 00 base word, 01 loop word, 10 read-modify-write, 11 link word. A base word sets the bus base byte address to its bits [27:0] shifted left by 4. Bit 28 set makes later pairs writes. Bit 29 drives `bus_apb`. Each word of a pair is addressed at base plus 4 times its word index.
- R3: A link word carries a first pair in bits [14:0] (offset [7:0], count [14:8]) and a second pair in bits [29:15] (offset [22:15], count [29:23]). The first pair is handled before the second. A pair whose count is 0 is skipped.
- R4: After a base word, the first pair starts at word index equal to its offset. Every later pair under the same base word, including pairs in later link words, starts at the index of the last word of the previous pair plus its offset.
- R5: Each word read on the bus is written to the SRAM at `wr_ptr`, which then advances by one, so that captured words sit at consecutive indices from `data_base`.
- R6: In write mode, a link word is followed by one data word. That data word is written on the bus to every address the link's pairs cover, with `bus_we` at 1, and nothing is stored in the SRAM.
- R7: A loop word holds a jump distance in bits [LOOP_SHIFT-1:0] and a repeat count in the 8 bits above. When the walk reaches it, the walk moves back by the jump distance, so the loop body runs count+1 times in all. The repeat count is reloaded each time a fresh loop is entered, and a count of 0 gives a single pass.
- R8: A read-modify-write word is followed by a mask word and a value word. The engine writes (last captured word AND NOT mask) OR value on the bus, to the address of the last captured word.
- R9: The word 0xC0000000 ends the walk. `done` is then high for exactly one cycle and `err` is 0.
- R10: A bus error response aborts the walk. `done` pulses with `err` at 1, and `wr_ptr` stays at the index after the last word stored.
- R11: While `bus_req` is high and neither `bus_ack` nor `bus_err` has been seen, the request address and direction stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (taken only while idle) |
| list_base | input | AW | SRAM index of the first descriptor |
| data_base | input | AW | SRAM index for the first captured word |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse at the end of a walk |
| err | output | 1 | Last walk ended on a bus error |
| wr_ptr | output | AW | Next SRAM index for a captured word |
| mem_en | output | 1 | SRAM access enable |
| mem_we | output | 1 | SRAM write enable |
| mem_addr | output | AW | SRAM word index |
| mem_wdata | output | 32 | SRAM write data |
| mem_rdata | input | 32 | SRAM read data, one cycle after a read |
| bus_req | output | 1 | Bus request, held until response |
| bus_we | output | 1 | Bus write when 1, read when 0 |
| bus_apb | output | 1 | Bus select flag from the base word |
| bus_addr | output | 32 | Bus byte address |
| bus_wdata | output | 32 | Bus write data |
| bus_ack | input | 1 | Bus response, success |
| bus_err | input | 1 | Bus response, error |
| bus_rdata | input | 32 | Bus read data, valid with `bus_ack` |

## Verification
The bench builds the engine with AW = 8 and LOOP_SHIFT = 8. A 256-word SRAM then holds both the list and a 128-word capture area, and the loop repeat count sits at bits [15:8], where loop words are easy to hand-encode. With this narrow shift, both the jump and the count fields of loop words are exercised. Random lists of chained pairs, with variable bus latency, can run to fifty-odd captured words without wrapping the data area.

// File: rtl/lcap_pkg.sv
package lcap_pkg;

    localparam logic [31:0] LCAP_END_WORD = 32'hC000_0000;

    typedef enum logic [1:0] {
        DK_BASE = 2'b00,
        DK_LOOP = 2'b01,
        DK_RMW  = 2'b10,
        DK_LINK = 2'b11
    } dkind_e;

    typedef enum logic [1:0] {
        WK_DESC,
        WK_DATA,
        WK_MASK,
        WK_VALUE
    } wkind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_WORD,
        ST_PAIR,
        ST_BUS,
        ST_RMW,
        ST_DONE
    } state_e;

    typedef struct packed {
        logic [6:0] len;
        logic [7:0] off;
    } pair_t;

    typedef struct packed {
        logic        apb;
        logic        wr;
        logic [27:0] addr;
    } basew_t;

    function automatic logic [31:0] base_to_byte(input logic [27:0] f);
        return {f, 4'b0000};
    endfunction

    function automatic logic [31:0] merge_rmw(input logic [31:0] old_w,
                                              input logic [31:0] mask_w,
                                              input logic [31:0] val_w);
        return (old_w & ~mask_w) | val_w;
    endfunction

endpackage

// File: rtl/lcap_decode.sv
module lcap_decode
    import lcap_pkg::*;
#(
    parameter int LOOP_SHIFT = 12,
    parameter int CNT_W      = 8
) (
    input  logic [31:0]           word,
    output dkind_e                kind,
    output basew_t                basef,
    output pair_t                 pair_lo,
    output pair_t                 pair_hi,
    output logic [LOOP_SHIFT-1:0] loop_back,
    output logic [CNT_W-1:0]      loop_cnt,
    output logic                  is_end
);
    assign kind      = dkind_e'(word[31:30]);
    assign basef     = word[29:0];
    assign pair_lo   = word[14:0];
    assign pair_hi   = word[29:15];
    assign loop_back = word[LOOP_SHIFT-1:0];
    assign loop_cnt  = word[LOOP_SHIFT+CNT_W-1:LOOP_SHIFT];
    assign is_end    = (word == LCAP_END_WORD);
endmodule

// File: rtl/lcap_loop.sv
module lcap_loop #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             hit,
    input  logic [CNT_W-1:0] cnt,
    output logic             take
);
    logic             active;
    logic [CNT_W-1:0] rem;
    logic [CNT_W-1:0] eff;

    always_comb begin
        eff  = active ? rem : cnt;
        take = hit && (eff != '0);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            active <= 1'b0;
            rem    <= '0;
        end else if (hit) begin
            if (eff != '0) begin
                active <= 1'b1;
                rem    <= eff - 1'b1;
            end else begin
                active <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/lcap_engine.sv
module lcap_engine
    import lcap_pkg::*;
#(
    parameter int AW         = 10,
    parameter int LOOP_SHIFT = 12,
    parameter int IDX_W      = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] list_base,
    input  logic [AW-1:0] data_base,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic [AW-1:0] wr_ptr,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic          bus_req,
    output logic          bus_we,
    output logic          bus_apb,
    output logic [31:0]   bus_addr,
    output logic [31:0]   bus_wdata,
    input  logic          bus_ack,
    input  logic          bus_err,
    input  logic [31:0]   bus_rdata
);
    localparam int CNT_W = 8;

    state_e             state;
    wkind_e             want;
    logic [AW-1:0]      lptr;
    logic [AW-1:0]      dptr;
    logic [31:0]        base_q;
    logic               wmode_q;
    logic               apb_q;
    logic [IDX_W-1:0]   anchor;
    logic [IDX_W-1:0]   cur_idx;
    logic [6:0]         left;
    pair_t              plo_q;
    pair_t              phi_q;
    logic               psel;
    logic [31:0]        wdata_q;
    logic [31:0]        mask_q;
    logic [31:0]        last_addr;
    logic [31:0]        last_data;
    logic               err_q;

    dkind_e                d_kind;
    basew_t                d_base;
    pair_t                 d_plo;
    pair_t                 d_phi;
    logic [LOOP_SHIFT-1:0] d_back;
    logic [CNT_W-1:0]      d_cnt;
    logic                  d_end;

    lcap_decode #(.LOOP_SHIFT(LOOP_SHIFT), .CNT_W(CNT_W)) u_dec (
        .word      (mem_rdata),
        .kind      (d_kind),
        .basef     (d_base),
        .pair_lo   (d_plo),
        .pair_hi   (d_phi),
        .loop_back (d_back),
        .loop_cnt  (d_cnt),
        .is_end    (d_end)
    );

    logic loop_hit;
    logic loop_take;
    logic loop_clear;

    assign loop_hit   = (state == ST_WORD) && (want == WK_DESC) && (d_kind == DK_LOOP);
    assign loop_clear = (state == ST_IDLE) && start;

    lcap_loop #(.CNT_W(CNT_W)) u_loop (
        .clk   (clk),
        .rst   (rst),
        .clear (loop_clear),
        .hit   (loop_hit),
        .cnt   (d_cnt),
        .take  (loop_take)
    );

    pair_t            cur_pair;
    logic [AW-1:0]    back_idx;
    logic [31:0]      pair_addr;
    logic             rd_ok;

    assign cur_pair  = psel ? phi_q : plo_q;
    assign back_idx  = AW'(d_back);
    assign pair_addr = base_q + 32'({cur_idx, 2'b00});
    assign rd_ok     = (state == ST_BUS) && bus_ack && !bus_err && !wmode_q;

    always_comb begin
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_apb   = apb_q;
        bus_addr  = pair_addr;
        bus_wdata = wdata_q;
        if (state == ST_BUS) begin
            bus_req = 1'b1;
            bus_we  = wmode_q;
        end else if (state == ST_RMW) begin
            bus_req   = 1'b1;
            bus_we    = 1'b1;
            bus_addr  = last_addr;
            bus_wdata = merge_rmw(last_data, mask_q, wdata_q);
        end
    end

    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = lptr;
        mem_wdata = bus_rdata;
        if (state == ST_RD) begin
            mem_en = 1'b1;
        end else if (rd_ok) begin
            mem_en   = 1'b1;
            mem_we   = 1'b1;
            mem_addr = dptr;
        end
    end

    assign busy   = (state != ST_IDLE);
    assign done   = (state == ST_DONE);
    assign err    = err_q;
    assign wr_ptr = dptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            want      <= WK_DESC;
            lptr      <= '0;
            dptr      <= '0;
            base_q    <= '0;
            wmode_q   <= 1'b0;
            apb_q     <= 1'b0;
            anchor    <= '0;
            cur_idx   <= '0;
            left      <= '0;
            plo_q     <= '0;
            phi_q     <= '0;
            psel      <= 1'b0;
            wdata_q   <= '0;
            mask_q    <= '0;
            last_addr <= '0;
            last_data <= '0;
            err_q     <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        lptr    <= list_base;
                        dptr    <= data_base;
                        err_q   <= 1'b0;
                        want    <= WK_DESC;
                        anchor  <= '0;
                        base_q  <= '0;
                        wmode_q <= 1'b0;
                        apb_q   <= 1'b0;
                        state   <= ST_RD;
                    end
                end
                ST_RD: state <= ST_WORD;
                ST_WORD: begin
                    lptr  <= lptr + 1'b1;
                    want  <= WK_DESC;
                    state <= ST_RD;
                    case (want)
                        WK_DESC: begin
                            case (d_kind)
                                DK_BASE: begin
                                    base_q  <= base_to_byte(d_base.addr);
                                    wmode_q <= d_base.wr;
                                    apb_q   <= d_base.apb;
                                    anchor  <= '0;
                                end
                                DK_LOOP: begin
                                    if (loop_take) lptr <= lptr - back_idx;
                                end
                                DK_RMW: want <= WK_MASK;
                                default: begin
                                    if (d_end) begin
                                        state <= ST_DONE;
                                    end else begin
                                        plo_q <= d_plo;
                                        phi_q <= d_phi;
                                        psel  <= 1'b0;
                                        if (wmode_q) want <= WK_DATA;
                                        else state <= ST_PAIR;
                                    end
                                end
                            endcase
                        end
                        WK_DATA: begin
                            wdata_q <= mem_rdata;
                            state   <= ST_PAIR;
                        end
                        WK_MASK: begin
                            mask_q <= mem_rdata;
                            want   <= WK_VALUE;
                        end
                        default: begin
                            wdata_q <= mem_rdata;
                            state   <= ST_RMW;
                        end
                    endcase
                end
                ST_PAIR: begin
                    if (cur_pair.len == '0) begin
                        if (!psel) psel <= 1'b1;
                        else state <= ST_RD;
                    end else begin
                        cur_idx <= anchor + IDX_W'(cur_pair.off);
                        left    <= cur_pair.len;
                        state   <= ST_BUS;
                    end
                end
                ST_BUS: begin
                    if (bus_err) begin
                        err_q <= 1'b1;
                        state <= ST_DONE;
                    end else if (bus_ack) begin
                        if (!wmode_q) begin
                            dptr      <= dptr + 1'b1;
                            last_addr <= pair_addr;
                            last_data <= bus_rdata;
                        end
                        cur_idx <= cur_idx + 1'b1;
                        left    <= left - 1'b1;
                        if (left == 7'd1) begin
                            anchor <= cur_idx;
                            if (!psel) begin
                                psel  <= 1'b1;
                                state <= ST_PAIR;
                            end else begin
                                state <= ST_RD;
                            end
                        end
                    end
                end
                ST_RMW: begin
                    if (bus_err) begin
                        err_q <= 1'b1;
                        state <= ST_DONE;
                    end else if (bus_ack) begin
                        state <= ST_RD;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lcap_checker.sv
module lcap_checker #(
    parameter int AW = 10
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          done,
    input logic          err,
    input logic [AW-1:0] wr_ptr,
    input logic          mem_en,
    input logic          mem_we,
    input logic          bus_req,
    input logic          bus_we,
    input logic [31:0]   bus_addr,
    input logic          bus_ack,
    input logic          bus_err
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!bus_req && !mem_en && !done)); // R1

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack && !bus_err) |=> (bus_req && $stable(bus_addr) && $stable(bus_we))); // R11

    AST_STORE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (wr_ptr == AW'($past(wr_ptr) + 1'b1))); // R5

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9

    AST_ERR_ABORT: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_err) |=> (done && err)); // R10

    AST_NO_STORE_ON_ERR: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_err) |-> !mem_we); // R10
endmodule

bind lcap_engine lcap_checker #(.AW(AW)) u_lcap_checker (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .wr_ptr   (wr_ptr),
    .mem_en   (mem_en),
    .mem_we   (mem_we),
    .bus_req  (bus_req),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_ack  (bus_ack),
    .bus_err  (bus_err)
);

// File: tb/tb_lcap_engine.sv
`timescale 1ns/1ps
module tb_lcap_engine;
    localparam int AW = 8;
    localparam int LS = 8;
    localparam int DB = 128;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] list_base = '0;
    logic [AW-1:0] data_base = '0;
    logic          busy, done, err;
    logic [AW-1:0] wr_ptr;
    logic          mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic [31:0]   mem_rdata = '0;
    logic          bus_req, bus_we, bus_apb;
    logic [31:0]   bus_addr, bus_wdata;
    logic          bus_ack = 1'b0;
    logic          bus_err = 1'b0;
    logic [31:0]   bus_rdata = '0;

    always #2.5 clk = ~clk;

    lcap_engine #(.AW(AW), .LOOP_SHIFT(LS)) dut (
        .clk(clk), .rst(rst), .start(start), .list_base(list_base), .data_base(data_base),
        .busy(busy), .done(done), .err(err), .wr_ptr(wr_ptr),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .bus_req(bus_req), .bus_we(bus_we), .bus_apb(bus_apb),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_err(bus_err),
        .bus_rdata(bus_rdata)
    );

    logic [31:0] sram [256];
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) sram[mem_addr] <= mem_wdata;
            else mem_rdata <= sram[mem_addr];
        end
    end

    function automatic logic [31:0] fval(input logic [31:0] a);
        return {a[15:0], ~a[15:0]} ^ 32'h1357_9BDF;
    endfunction

    logic [31:0] wl_addr [64];
    logic [31:0] wl_data [64];
    logic        wl_apb  [64];
    int          wcnt = 0;
    bit          err_en = 0;
    logic [31:0] err_addr = '0;
    int          lat = 0;

    always @(negedge clk) begin
        if (bus_ack || bus_err) begin
            bus_ack <= 1'b0;
            bus_err <= 1'b0;
        end else if (bus_req) begin
            if (lat == 0) begin
                lat <= int'($urandom % 3);
                if (err_en && bus_addr == err_addr) begin
                    bus_err <= 1'b1;
                end else begin
                    bus_ack   <= 1'b1;
                    bus_rdata <= fval(bus_addr);
                    if (bus_we && wcnt < 64) begin
                        wl_addr[wcnt] <= bus_addr;
                        wl_data[wcnt] <= bus_wdata;
                        wl_apb[wcnt]  <= bus_apb;
                        wcnt <= wcnt + 1;
                    end
                end
            end else begin
                lat <= lat - 1;
            end
        end
    end

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] w_base(input logic [27:0] a, input bit wr, input bit apb);
        return {2'b00, apb, wr, a};
    endfunction
    function automatic logic [31:0] w_link(input int o0, input int l0, input int o1, input int l1);
        return {2'b11, 7'(l1), 8'(o1), 7'(l0), 8'(o0)};
    endfunction
    function automatic logic [31:0] w_loop(input int back, input int cnt);
        return {2'b01, 14'd0, 8'(cnt), 8'(back)};
    endfunction
    localparam logic [31:0] W_RMW = 32'h8000_0000;
    localparam logic [31:0] W_END = 32'hC000_0000;

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) sram[i] = 32'hDEDE_DEDE;
    endtask

    task automatic run(input string req);
        int cyc;
        wcnt = 0;
        @(negedge clk);
        list_base = '0;
        data_base = AW'(DB);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        chk(done, req, "walk completes", 32'(done), 32'd1);
    endtask

    logic [31:0] exp_a [128];
    int          exp_n;

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !err && !bus_req && !mem_en, "R1", "reset idle state",
            {busy, done, err, bus_req, mem_en}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !bus_req, "R1", "idle after reset", {busy, bus_req}, 32'd0);
        void'($urandom(32'd4242));

        // R2 R4 R5 R9: two chained pairs
        clear_mem();
        sram[0] = w_base(28'h1, 0, 0);
        sram[1] = w_link(2, 3, 1, 2);
        sram[2] = W_END;
        run("R9");
        chk(!err, "R9", "end marker no error", 32'(err), 32'd0);
        @(negedge clk);
        chk(!done, "R9", "done single cycle", 32'(done), 32'd0);
        chk(wr_ptr == AW'(DB + 5), "R5", "capture count", 32'(wr_ptr), DB + 5);
        begin
            logic [31:0] ea [5] = '{32'h18, 32'h1C, 32'h20, 32'h24, 32'h28};
            for (int k = 0; k < 5; k++)
                chk(sram[DB + k] == fval(ea[k]), "R4", "chained pair data", sram[DB + k], fval(ea[k]));
        end

        // R3: zero-count pairs skipped
        clear_mem();
        sram[0] = w_base(28'h10, 0, 0);
        sram[1] = w_link(0, 0, 3, 2);
        sram[2] = w_link(1, 1, 7, 0);
        sram[3] = W_END;
        run("R3");
        chk(wr_ptr == AW'(DB + 3), "R3", "skipped pair count", 32'(wr_ptr), DB + 3);
        chk(sram[DB] == fval(32'h10C), "R3", "second pair only", sram[DB], fval(32'h10C));
        chk(sram[DB + 2] == fval(32'h114), "R3", "first pair of next link", sram[DB + 2], fval(32'h114));

        // R6 R2: write mode with bus select
        clear_mem();
        sram[0] = w_base(28'h100, 1, 1);
        sram[1] = w_link(3, 2, 0, 0);
        sram[2] = 32'hCAFE_F00D;
        sram[3] = W_END;
        run("R6");
        chk(wr_ptr == AW'(DB), "R6", "nothing captured", 32'(wr_ptr), DB);
        chk(wcnt == 2, "R6", "write count", 32'(wcnt), 32'd2);
        chk(wl_addr[0] == 32'h100C && wl_addr[1] == 32'h1010, "R6", "write addresses", wl_addr[1], 32'h1010);
        chk(wl_data[0] == 32'hCAFE_F00D && wl_data[1] == 32'hCAFE_F00D, "R6", "write data", wl_data[0], 32'hCAFE_F00D);
        chk(wl_apb[0] && wl_apb[1], "R2", "bus select flag", 32'(wl_apb[0]), 32'd1);
        chk(sram[DB] == 32'hDEDE_DEDE, "R6", "capture area untouched", sram[DB], 32'hDEDE_DEDE);

        // R7: two sequential loops, reload on second entry
        clear_mem();
        sram[0] = w_base(28'h20, 0, 0);
        sram[1] = w_link(1, 1, 0, 0);
        sram[2] = w_loop(2, 1);
        sram[3] = w_base(28'h30, 0, 0);
        sram[4] = w_link(0, 1, 0, 0);
        sram[5] = w_loop(2, 2);
        sram[6] = W_END;
        run("R7");
        chk(wr_ptr == AW'(DB + 5), "R7", "loop pass total", 32'(wr_ptr), DB + 5);
        chk(sram[DB + 1] == fval(32'h204) && sram[DB + 2] == fval(32'h300) && sram[DB + 4] == fval(32'h300),
            "R7", "loop captured data", sram[DB + 4], fval(32'h300));
        sram[5] = w_loop(2, 0);
        run("R7");
        chk(wr_ptr == AW'(DB + 3), "R7", "count zero single pass", 32'(wr_ptr), DB + 3);

        // R8: read-modify-write
        clear_mem();
        sram[0] = w_base(28'h40, 0, 0);
        sram[1] = w_link(1, 1, 0, 0);
        sram[2] = W_RMW;
        sram[3] = 32'h0000_FF00;
        sram[4] = 32'h0000_0012;
        sram[5] = W_END;
        run("R8");
        chk(wcnt == 1 && wl_addr[0] == 32'h404, "R8", "rmw address", wl_addr[0], 32'h404);
        chk(wl_data[0] == ((fval(32'h404) & ~32'h0000_FF00) | 32'h12), "R8", "rmw data",
            wl_data[0], (fval(32'h404) & ~32'h0000_FF00) | 32'h12);
        chk(wr_ptr == AW'(DB + 1), "R8", "rmw stores nothing", 32'(wr_ptr), DB + 1);

        // R10: bus error abort
        clear_mem();
        sram[0] = w_base(28'h50, 0, 0);
        sram[1] = w_link(0, 4, 0, 0);
        sram[2] = W_END;
        err_en = 1;
        err_addr = 32'h508;
        run("R10");
        chk(err, "R10", "error flag", 32'(err), 32'd1);
        chk(wr_ptr == AW'(DB + 2), "R10", "pointer at last stored", 32'(wr_ptr), DB + 2);
        chk(sram[DB + 2] == 32'hDEDE_DEDE, "R10", "no store after error", sram[DB + 2], 32'hDEDE_DEDE);
        err_en = 0;

        // R4 R5 R3: random chained lists
        for (int it = 0; it < 20; it++) begin
            int li;
            int nb;
            int bad;
            clear_mem();
            li = 0;
            exp_n = 0;
            nb = 1 + int'($urandom % 3);
            for (int b = 0; b < nb; b++) begin
                logic [27:0] bf;
                int anc;
                int nl;
                bf = 28'($urandom & 32'h000F_FFFF);
                sram[li] = w_base(bf, 0, 0);
                li++;
                anc = 0;
                nl = 1 + int'($urandom % 3);
                for (int l = 0; l < nl; l++) begin
                    int o [2];
                    int n [2];
                    o[0] = int'($urandom % 5);
                    n[0] = 1 + int'($urandom % 3);
                    o[1] = int'($urandom % 5);
                    n[1] = int'($urandom % 4);
                    sram[li] = w_link(o[0], n[0], o[1], n[1]);
                    li++;
                    for (int p = 0; p < 2; p++) begin
                        if (n[p] > 0) begin
                            int s;
                            s = anc + o[p];
                            for (int i = 0; i < n[p]; i++) begin
                                exp_a[exp_n] = {bf, 4'b0} + 32'((s + i) * 4);
                                exp_n++;
                            end
                            anc = s + n[p] - 1;
                        end
                    end
                end
            end
            sram[li] = W_END;
            run("R4");
            chk(wr_ptr == AW'(DB + exp_n), "R5", "random capture count", 32'(wr_ptr), 32'(DB + exp_n));
            bad = 0;
            for (int k = 0; k < exp_n; k++)
                if (sram[DB + k] != fval(exp_a[k])) bad++;
            chk(bad == 0, "R4", "random captured data mismatches", 32'(bad), 32'd0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual 0x0 expected 0x1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule